// File: doc/BRIEF.md
# Glitch-free two-source clock switchover

This block picks one of two reference clocks and passes it to a single output clock. Software or board logic moves the output from one source to the other with a request line. Each accepted rising edge of the request flips the selection, and repeated requests alternate between the two sources. The request counts only once it has stayed high for a minimum number of reference clock cycles, so short spikes on the line are ignored.

The handover is break-before-make. The source being left is gated off on one of its own falling edges. The new source is gated on at one of its own falling edges, and only after it has seen that the old gate is off. A target clock that is not toggling can never raise its gate, so the controller simply waits until that clock starts.

A free-running monitor clock watches both sources and raises a per-source dead flag when a source stops toggling. An indicator output reports which source currently drives the output. The dead flags are status only: they never start a switch.

Top module: `glitchless_clk_switch`

## Requirements
- R1: After reset, `active_sel` is 0, `clk_out` follows source A (`ref_clk[0]`) and both `clk_dead` bits are 0.
- R2: A rising edge of `swap_req` that is then held for at least MIN_HIGH (default 3) cycles of the slower reference clock flips the selection. Afterwards `clk_out` follows the other source.
- R3: A `swap_req` pulse shorter than one period of the faster reference clock is ignored: the selection and `clk_out` do not change.
- R4: Holding `swap_req` high causes exactly one switch. The line must return low before another switch can be accepted.
- R5: Successive qualified pulses alternate the output between source A and source B.
- R6: Every high phase of `clk_out` is one complete high phase of a single source. The two source gates are never open at the same time.
- R7: If the target source is not toggling, `clk_out` stays low after the old source is gated off. The switch completes once the target starts toggling.
- R8: `active_sel` is 0 when source A drives `clk_out` and 1 when source B does. It changes only after the gate change, and it keeps its last value while neither gate is open.
- R9: `clk_dead[i]` goes high when `mon_clk` sees no activity on source i for DEAD_LIMIT (default 16) monitor cycles. It clears once activity resumes.
- R10: A dead flag on its own never changes the selection or `active_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 2 | Reference clocks: bit 0 is source A, bit 1 is source B |
| mon_clk | input | 1 | Free-running clock for the control logic and the activity monitors |
| rst_n | input | 1 | Active-low reset, sampled synchronously in every clock domain |
| swap_req | input | 1 | Switch request; a qualified rising edge flips the selection |
| clk_out | output | 1 | Gated, multiplexed output clock |
| active_sel | output | 1 | Source driving `clk_out` (0 = A, 1 = B) |
| clk_dead | output | 2 | Per-source dead flags (bit i belongs to `ref_clk[i]`) |

## Verification
The assertions take the following for granted:
- All three clocks toggle while reset is held.
- `mon_clk` samples each source's activity toggle well inside DEAD_LIMIT monitor cycles.
- A new request arrives only after the previous handover has settled.
- Request pulses are either clearly long enough for the slower source or clearly shorter than a period of the faster one.

The stimulus stays within these limits:
- Long pulses last at least 50 ns against a 14 ns slower period.
- Short pulses last at most 6 ns against a 10 ns faster period.
- Every pulse is followed by a 400 ns settling gap.
- Source B is stopped only while source A is the live selection.

// File: rtl/csw_pkg.sv
// Package: shared types and helpers for the clock switchover block.
// Assumes exactly two reference sources, indexed 0 (A) and 1 (B).
package csw_pkg;
    localparam int unsigned NSRC = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    // One-hot gate pattern expected when source 'sel' is the live one.
    function automatic src_vec_t src_onehot(input logic sel);
        return sel ? src_vec_t'(2'b10) : src_vec_t'(2'b01);
    endfunction
endpackage

// File: rtl/csw_sync.sv
// Module: multi-stage flop synchronizer for a single level signal.
// Assumes STAGES >= 2 and a level input that is stable for several
// destination cycles. Reset value is a parameter.
module csw_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csw_req_qual.sv
// Module: request qualifier in one reference clock domain.
// Synchronizes the request, counts consecutive high cycles and raises
// qual_o after MIN_HIGH of them. qual_o stays high until the request
// goes low, so one held request gives one qualification.
// Assumes MIN_HIGH >= 1.
module csw_req_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HIGH    = 3
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_HIGH);

    logic          req_s;
    logic [CW-1:0] cnt_q;

    csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    // Count high cycles of the synced request and flag qualification.
    always_ff @(posedge clk_i) begin
        if (!rst_n || !req_s) begin
            cnt_q  <= '0;
            qual_o <= 1'b0;
        end else begin
            if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
            qual_o <= (cnt_q >= LIM - 1'b1);
        end
    end

    // R3: qualification only ever rises while the synced request is high.
    p_qual_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(qual_o) |-> $past(req_s));
endmodule

// File: rtl/csw_gate.sv
// Module: gate-enable cell for one reference source.
// The enable flop sits on the source's falling edge, so the gate opens
// and closes only while that source is low. It opens only when the
// source is wanted and the other source's enable, synchronized here,
// reads closed. A stopped source never changes its enable.
// Assumes the want level changes only after a handover has settled.
module csw_gate #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RST_EN      = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic want_i,
    input  logic other_en_i,
    output logic en_o
);
    logic want_s;
    logic other_s;

    csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_EN)) i_want_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (want_i),
        .q_o   (want_s)
    );

    csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(~RST_EN)) i_other_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (other_en_i),
        .q_o   (other_s)
    );

    // Update the gate enable on the falling edge of this source.
    always_ff @(negedge clk_i) begin
        if (!rst_n) en_o <= RST_EN;
        else        en_o <= want_s & ~other_s;
    end
endmodule

// File: rtl/csw_activity_mon.sv
// Module: activity monitor for one reference source.
// A toggle flop in the source domain flips on every rising edge. The
// monitor domain synchronizes it and counts monitor cycles without a
// change. dead_o rises at DEAD_LIMIT and clears on the next change.
// Assumes mon_clk is fast enough to see every toggle.
module csw_activity_mon #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEAD_LIMIT  = 16
) (
    input  logic clk_i,
    input  logic mon_clk,
    input  logic rst_n,
    output logic dead_o
);
    localparam int unsigned CW = $clog2(DEAD_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(DEAD_LIMIT);

    logic          tog_q;
    logic          tog_s;
    logic          tog_d;
    logic          chg;
    logic [CW-1:0] idle_q;

    // Flip a marker on each source edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_tog_sync (
        .clk_i (mon_clk),
        .rst_n (rst_n),
        .d_i   (tog_q),
        .q_o   (tog_s)
    );

    assign chg = tog_s ^ tog_d;

    // Count idle monitor cycles and raise or clear the dead flag.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            tog_d  <= 1'b0;
            idle_q <= '0;
            dead_o <= 1'b0;
        end else begin
            tog_d <= tog_s;
            if (chg) begin
                idle_q <= '0;
                dead_o <= 1'b0;
            end else if (idle_q != LIM) begin
                idle_q <= idle_q + 1'b1;
            end else begin
                dead_o <= 1'b1;
            end
        end
    end

    // R9: the flag rises only after a cycle with no observed activity.
    p_dead_needs_idle_r9: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $rose(dead_o) |-> $past(!chg));
    // R9: observed activity clears the flag on the next cycle.
    p_dead_clears_r9: assert property (@(posedge mon_clk) disable iff (!rst_n)
        chg |=> !dead_o);
endmodule

// File: rtl/glitchless_clk_switch.sv
// Module: glitch-free two-source clock switchover, top level.
// Per source: a request qualifier, a falling-edge gate cell and an
// activity monitor. In the monitor domain, a qualified request edge
// flips the selection. A flip that arrives during a handover is held
// pending until the gates settle, or until they are both closed and
// the target is dead. clk_out is the OR of the gated sources.
// Assumes all clocks toggle during reset.
module glitchless_clk_switch #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HIGH    = 3,
    parameter int unsigned DEAD_LIMIT  = 16
) (
    input  logic [1:0] ref_clk,
    input  logic       mon_clk,
    input  logic       rst_n,
    input  logic       swap_req,
    output logic       clk_out,
    output logic       active_sel,
    output logic [1:0] clk_dead
);
    import csw_pkg::*;

    src_vec_t qual;
    src_vec_t qual_m;
    src_vec_t en;
    src_vec_t en_m;
    src_vec_t want;
    src_vec_t dead;

    logic sel_q;
    logic pend_q;
    logic act_q;
    logic any_d;
    logic any_qual;
    logic req_evt;
    logic settled;
    logic stalled;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic IS_A = (i == 0) ? 1'b1 : 1'b0;

        assign want[i] = IS_A ? ~sel_q : sel_q;

        csw_req_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_HIGH(MIN_HIGH)) i_qual (
            .clk_i  (ref_clk[i]),
            .rst_n  (rst_n),
            .req_i  (swap_req),
            .qual_o (qual[i])
        );

        csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_qual_sync (
            .clk_i (mon_clk),
            .rst_n (rst_n),
            .d_i   (qual[i]),
            .q_o   (qual_m[i])
        );

        csw_gate #(.SYNC_STAGES(SYNC_STAGES), .RST_EN(IS_A)) i_gate (
            .clk_i      (ref_clk[i]),
            .rst_n      (rst_n),
            .want_i     (want[i]),
            .other_en_i (en[NSRC-1-i]),
            .en_o       (en[i])
        );

        csw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IS_A)) i_en_sync (
            .clk_i (mon_clk),
            .rst_n (rst_n),
            .d_i   (en[i]),
            .q_o   (en_m[i])
        );

        csw_activity_mon #(.SYNC_STAGES(SYNC_STAGES), .DEAD_LIMIT(DEAD_LIMIT)) i_mon (
            .clk_i   (ref_clk[i]),
            .mon_clk (mon_clk),
            .rst_n   (rst_n),
            .dead_o  (dead[i])
        );
    end

    assign any_qual = |qual_m;
    assign req_evt  = any_qual & ~any_d;
    assign settled  = (en_m == src_onehot(sel_q));
    assign stalled  = (en_m == '0) && dead[sel_q];

    // Selection control: flip on a request edge once the gates allow it.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            pend_q <= 1'b0;
            any_d  <= 1'b0;
        end else begin
            any_d <= any_qual;
            if (req_evt || pend_q) begin
                if (settled || stalled) begin
                    sel_q  <= ~sel_q;
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

    // Active indicator: follow whichever gate is open, hold when none is.
    always_ff @(posedge mon_clk) begin
        if (!rst_n)                act_q <= 1'b0;
        else if (en_m == 2'b01)    act_q <= 1'b0;
        else if (en_m == 2'b10)    act_q <= 1'b1;
    end

    assign clk_out    = |(ref_clk & en);
    assign active_sel = act_q;
    assign clk_dead   = dead;

    // R6: the two gates are never seen open together.
    p_gates_exclusive_r6: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !(en_m[0] && en_m[1]));
    // R2, R10: the selection moves only on a request edge or a held flip.
    p_sel_moves_on_request_r10: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(req_evt || pend_q));
    // R8: the indicator only ever moves to the source that was selected.
    p_active_tracks_sel_r8: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !$stable(act_q) |-> (act_q == $past(sel_q)));
    // R4: a flip is never taken while the request stays qualified.
    p_one_flip_per_edge_r4: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (any_qual && any_d && !pend_q) |=> $stable(sel_q));
endmodule

// File: tb/test_glitchless_clk_switch.sv
`timescale 1ns/1ps
module test_glitchless_clk_switch;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic mon_clk = 1'b0;
    logic b_run = 1'b1;
    logic rst_n = 1'b0;
    logic swap_req = 1'b0;
    logic clk_out;
    logic active_sel;
    logic [1:0] clk_dead;
    wire  [1:0] ref_clk = {clk_b, clk_a};

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    int n_rise = 0;
    bit exp_sel = 1'b0;
    bit armed = 1'b0;
    realtime t_rise = 0.0;
    real last_w = 0.0;

    glitchless_clk_switch i_glitchless_clk_switch (
        .ref_clk    (ref_clk),
        .mon_clk    (mon_clk),
        .rst_n      (rst_n),
        .swap_req   (swap_req),
        .clk_out    (clk_out),
        .active_sel (active_sel),
        .clk_dead   (clk_dead)
    );

    always #2.5 mon_clk = ~mon_clk;
    always #5   clk_a = ~clk_a;
    always begin
        #7;
        if (b_run) clk_b = ~clk_b;
    end

    // Map a measured high-phase width to a source: 0 = A, 1 = B, -1 = none.
    function automatic int src_of_width(real w);
        if (w > 4.99 && w < 5.01) return 0;
        if (w > 6.99 && w < 7.01) return 1;
        return -1;
    endfunction

    always @(posedge clk_out) begin
        t_rise = $realtime;
        n_rise++;
    end

    always @(negedge clk_out) begin
        if (armed) begin
            last_w = $realtime - t_rise;
            if (src_of_width(last_w) < 0) glitches++;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(real len, bit counts);
        swap_req = 1'b1;
        #(len);
        swap_req = 1'b0;
        if (counts) exp_sel = ~exp_sel;
        #400;
        @(negedge mon_clk);
    endtask

    task automatic check_sel(string tag);
        check({tag, " active_sel"}, int'(active_sel), int'(exp_sel));
        check({tag, " clk_out source"}, src_of_width(last_w), int'(exp_sel));
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd4711));
        repeat (20) @(posedge mon_clk);
        #1 rst_n = 1'b1;
        @(negedge mon_clk);
        // R1: reset state
        check("R1 active_sel", int'(active_sel), 0);
        check("R1 clk_dead", int'(clk_dead), 0);
        armed = 1'b1;
        #200;
        @(negedge mon_clk);
        check("R1 clk_out source", src_of_width(last_w), 0);

        // R2: one qualified pulse switches to B
        pulse(80.0, 1'b1);
        check_sel("R2 R8");

        // R3: short pulse ignored
        pulse(4.0, 1'b0);
        check_sel("R3");

        // R4: held request switches once, then needs a low phase
        swap_req = 1'b1;
        exp_sel = ~exp_sel;
        #700;
        @(negedge mon_clk);
        check_sel("R4 held");
        swap_req = 1'b0;
        #400;
        @(negedge mon_clk);
        check_sel("R4 released");
        pulse(60.0, 1'b1);
        check_sel("R4 rearm");

        // R5: random mix of long and short pulses alternates the output
        for (int k = 0; k < 12; k++) begin
            if ($urandom % 4 == 0) pulse(real'(1 + $urandom % 6), 1'b0);
            else                   pulse(real'(50 + $urandom % 80), 1'b1);
            check_sel("R5");
        end

        // R9, R10: stop source B while A is live
        if (exp_sel) begin
            pulse(70.0, 1'b1);
            check_sel("R10 prep");
        end
        b_run = 1'b0;
        #300;
        @(negedge mon_clk);
        check("R9 dead B", int'(clk_dead[1]), 1);
        check("R9 live A", int'(clk_dead[0]), 0);
        check_sel("R10");

        // R7: switch towards the dead source waits with the output low
        swap_req = 1'b1;
        #80;
        swap_req = 1'b0;
        #400;
        @(negedge mon_clk);
        base = n_rise;
        #200;
        @(negedge mon_clk);
        check("R7 output held low", n_rise - base, 0);
        check("R8 held during gap", int'(active_sel), 0);
        b_run = 1'b1;
        exp_sel = 1'b1;
        #400;
        @(negedge mon_clk);
        check("R9 dead B cleared", int'(clk_dead[1]), 0);
        check_sel("R7 completes");

        // R6: no partial high phase on the output during the whole run
        check("R6 glitches", glitches, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule